// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog timer that software programs over a simple APB-style register port. A 32-bit down-counter runs while the run bit is set. The first time the counter reaches zero, the block raises an interrupt flag and starts again from the programmed reload value. If software has not acknowledged that flag by the time the counter reaches zero a second time, and the reset-enable bit is set, the block drives a system reset request. That request stays high until the block's own reset is applied.

Software keeps the system alive by writing the acknowledge register before the second expiry. Each write to that register clears the flag and restarts the count. The block also has a key register. Writing one specific 32-bit key value opens the other registers for writing, and writing any other value closes them again, so a runaway program is unlikely to stop the watchdog by accident. A reload value of zero makes the block expire almost at once, which gives a quick way to force a reset. Reads are captured in the APB setup phase and are valid in the access phase.

Top module: `wdog2_top`

## Requirements
- R1: After the synchronous reset, the block is in this state: reload value 0xFFFFFFFF, counter 0xFFFFFFFF, control 0, key register unlocked (reads 0), interrupt flag 0, `irq_o` 0 and `wdog_rst_o` 0.
- R2: While control bit 0 (run) is 1, the counter drops by one on every clock. While run is 0, the counter holds its value. The counter register returns the live count.
- R3: When run is 1 and the counter is zero at a clock edge, that edge sets the interrupt flag and reloads the counter from the reload value. After the enabling control write, the flag therefore rises L+1 clocks later, where L is the reload value.
- R4: When the counter reaches zero while the flag is still set, and control is 3 (run plus reset enable, bit 1), `wdog_rst_o` rises 2(L+1) clocks after the enabling write. It then stays high until the block reset, even if run is cleared.
- R5: With control bit 1 at 0, repeated expiries never raise `wdog_rst_o`, and the flag stays set.
- R6: A write of any value to the acknowledge register clears the flag and reloads the counter from the reload value, taking effect on the clock of the write. Acknowledging regularly keeps `wdog_rst_o` low.
- R7: A write to the reload register stores the value and loads it into the counter on the clock of the write.
- R8: Bit 0 of the raw status register is the flag whatever the state of run. Bit 0 of the masked status register is the flag ANDed with run. `irq_o` is a level that equals the masked bit.
- R9: A write of 0x1ACCE551 to the key register unlocks. A write of any other value locks. The key register reads 1 when locked and 0 when unlocked.
- R10: While locked, writes to the reload, control and acknowledge registers have no effect. Writes to the key register always take effect.
- R11: With a reload value of 0 and control 3, the flag rises one clock after the enabling write and `wdog_rst_o` rises one clock after that.
- R12: The byte addresses, with bits 1:0 zero, are: reload 0x000, counter 0x004, control 0x008, acknowledge 0x00C, raw status 0x010, masked status 0x014, key 0xC00. Reads of the acknowledge register return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | AW (12) | Byte address |
| pwdata | input | DW (32) | Write data |
| prdata | output | DW (32) | Read data, valid in the access phase |
| irq_o | output | 1 | Level interrupt (masked flag) |
| wdog_rst_o | output | 1 | Sticky system reset request |

## Verification
A write takes effect on the clock edge of its access phase. The bench's write task returns at the falling edge just after that clock, and all cycle counts are measured from there. After a control write that sets run, the flag and `irq_o` are due L+1 clocks later and `wdog_rst_o` 2(L+1) clocks later. The bench steps exactly L, L+1, 2(L+1)-1 and 2(L+1) cycles and samples the output pins at falling edges, so it sees both the cycle before each event and the cycle of it. Counter values are read only while the counter is stopped, or after an exact count of elapsed edges, which includes the edges taken up by the bus transfer that stops it.

// File: rtl/wdog2_pkg.sv
`timescale 1ns/1ps
package wdog2_pkg;

  localparam int NREG      = 7;
  localparam int IX_LOAD   = 0;
  localparam int IX_COUNT  = 1;
  localparam int IX_CTRL   = 2;
  localparam int IX_ACK    = 3;
  localparam int IX_RAW    = 4;
  localparam int IX_MASKED = 5;
  localparam int IX_KEY    = 6;

  localparam logic [31:0] UNLOCK_KEY = 32'h1ACC_E551;

  typedef struct packed {
    logic rst_en;
    logic run;
  } ctrl_t;

  function automatic logic [11:0] reg_offset(input int idx);
    case (idx)
      IX_LOAD:   reg_offset = 12'h000;
      IX_COUNT:  reg_offset = 12'h004;
      IX_CTRL:   reg_offset = 12'h008;
      IX_ACK:    reg_offset = 12'h00C;
      IX_RAW:    reg_offset = 12'h010;
      IX_MASKED: reg_offset = 12'h014;
      default:   reg_offset = 12'hC00;
    endcase
  endfunction

endpackage

// File: rtl/wdog2_decode.sv
`timescale 1ns/1ps
module wdog2_decode
  import wdog2_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic            psel,
  input  logic            penable,
  input  logic            pwrite,
  input  logic [AW-1:0]   paddr,
  output logic [NREG-1:0] hit,
  output logic            wr_cycle,
  output logic            rd_setup
);

  for (genvar i = 0; i < NREG; i++) begin : g_match
    localparam logic [AW-1:0] OFS = AW'(reg_offset(i));
    assign hit[i] = (paddr == OFS);
  end

  assign wr_cycle = psel & penable & pwrite;
  assign rd_setup = psel & ~penable & ~pwrite;

endmodule

// File: rtl/wdog2_keylock.sv
`timescale 1ns/1ps
module wdog2_keylock
  import wdog2_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          key_wr,
  input  logic [DW-1:0] wdata,
  output logic          locked
);

  localparam logic [DW-1:0] KEY = DW'(UNLOCK_KEY);

  always_ff @(posedge clk) begin
    if (rst) begin
      locked <= 1'b0;
    end else if (key_wr) begin
      locked <= (wdata != KEY);
    end
  end

endmodule

// File: rtl/wdog2_core.sv
`timescale 1ns/1ps
module wdog2_core
  import wdog2_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_load,
  input  logic          wr_ctrl,
  input  logic          wr_ack,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] load_q,
  output ctrl_t         ctrl_q,
  output logic [DW-1:0] cnt_q,
  output logic          raw_q,
  output logic          trip_q
);

  localparam logic [DW-1:0] ALL_ONES = '1;
  localparam logic [DW-1:0] ONE      = DW'(1);

  logic at_zero;
  logic expire;

  assign at_zero = (cnt_q == '0);
  assign expire  = ctrl_q.run & at_zero & ~wr_load & ~wr_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      load_q <= ALL_ONES;
      ctrl_q <= '0;
    end else begin
      if (wr_load) load_q <= wdata;
      if (wr_ctrl) ctrl_q <= ctrl_t'(wdata[1:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= ALL_ONES;
    end else if (wr_load) begin
      cnt_q <= wdata;
    end else if (wr_ack) begin
      cnt_q <= load_q;
    end else if (ctrl_q.run) begin
      cnt_q <= at_zero ? load_q : (cnt_q - ONE);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q  <= 1'b0;
      trip_q <= 1'b0;
    end else begin
      if (wr_ack)      raw_q <= 1'b0;
      else if (expire) raw_q <= 1'b1;
      if (expire && raw_q && ctrl_q.rst_en) trip_q <= 1'b1;
    end
  end

endmodule

// File: rtl/wdog2_top.sv
`timescale 1ns/1ps
module wdog2_top
  import wdog2_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [AW-1:0] paddr,
  input  logic [DW-1:0] pwdata,
  output logic [DW-1:0] prdata,
  output logic          irq_o,
  output logic          wdog_rst_o
);

  logic [NREG-1:0] hit;
  logic            wr_cycle;
  logic            rd_setup;
  logic            locked;
  logic            wr_en;
  logic            wr_load;
  logic            wr_ctrl;
  logic            wr_ack;
  logic            wr_key;
  logic [DW-1:0]   load_q;
  ctrl_t           ctrl_q;
  logic [DW-1:0]   cnt_q;
  logic            raw_q;
  logic            trip_q;
  logic [DW-1:0]   rvals [NREG];
  logic [DW-1:0]   rd_mux;

  wdog2_decode #(.AW(AW)) u_decode (
    .psel     (psel),
    .penable  (penable),
    .pwrite   (pwrite),
    .paddr    (paddr),
    .hit      (hit),
    .wr_cycle (wr_cycle),
    .rd_setup (rd_setup)
  );

  assign wr_en   = wr_cycle & ~locked;
  assign wr_load = wr_en & hit[IX_LOAD];
  assign wr_ctrl = wr_en & hit[IX_CTRL];
  assign wr_ack  = wr_en & hit[IX_ACK];
  assign wr_key  = wr_cycle & hit[IX_KEY];

  wdog2_keylock #(.DW(DW)) u_keylock (
    .clk    (clk),
    .rst    (rst),
    .key_wr (wr_key),
    .wdata  (pwdata),
    .locked (locked)
  );

  wdog2_core #(.DW(DW)) u_core (
    .clk     (clk),
    .rst     (rst),
    .wr_load (wr_load),
    .wr_ctrl (wr_ctrl),
    .wr_ack  (wr_ack),
    .wdata   (pwdata),
    .load_q  (load_q),
    .ctrl_q  (ctrl_q),
    .cnt_q   (cnt_q),
    .raw_q   (raw_q),
    .trip_q  (trip_q)
  );

  assign rvals[IX_LOAD]   = load_q;
  assign rvals[IX_COUNT]  = cnt_q;
  assign rvals[IX_CTRL]   = DW'(ctrl_q);
  assign rvals[IX_ACK]    = '0;
  assign rvals[IX_RAW]    = DW'(raw_q);
  assign rvals[IX_MASKED] = DW'(raw_q & ctrl_q.run);
  assign rvals[IX_KEY]    = DW'(locked);

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NREG; i++) begin
      if (hit[i]) rd_mux = rd_mux | rvals[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prdata <= '0;
    end else if (rd_setup) begin
      prdata <= rd_mux;
    end
  end

  assign irq_o      = raw_q & ctrl_q.run;
  assign wdog_rst_o = trip_q;

endmodule

// File: rtl/wdog2_chk.sv
`timescale 1ns/1ps
module wdog2_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          wdog_rst_o,
  input logic [DW-1:0] cnt_q,
  input logic [DW-1:0] load_q,
  input logic [1:0]    ctrl_q,
  input logic          raw_q,
  input logic          locked,
  input logic          wr_load,
  input logic          wr_ack
);

  a_r2_count_step: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[0] && cnt_q != '0 && !wr_load && !wr_ack) |=> (cnt_q == $past(cnt_q) - DW'(1)));

  a_r3_flag_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(raw_q) |-> $past(cnt_q == '0 && ctrl_q[0]));

  a_r4_rst_sticky: assert property (@(posedge clk) disable iff (rst)
    wdog_rst_o |=> wdog_rst_o);

  a_r4_rst_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(wdog_rst_o) |-> $past(raw_q && cnt_q == '0 && ctrl_q == 2'b11));

  a_r6_ack_clears: assert property (@(posedge clk) disable iff (rst)
    wr_ack |=> !raw_q);

  a_r10_locked_hold: assert property (@(posedge clk) disable iff (rst)
    locked |=> ($stable(load_q) && $stable(ctrl_q)));

endmodule

bind wdog2_top wdog2_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wdog_rst_o (wdog_rst_o),
  .cnt_q      (cnt_q),
  .load_q     (load_q),
  .ctrl_q     (ctrl_q),
  .raw_q      (raw_q),
  .locked     (locked),
  .wr_load    (wr_load),
  .wr_ack     (wr_ack)
);

// File: tb/tb_wdog2_top.sv
`timescale 1ns/1ps
module tb_wdog2_top;

  localparam logic [11:0] A_LOAD = 12'h000;
  localparam logic [11:0] A_CNT  = 12'h004;
  localparam logic [11:0] A_CTRL = 12'h008;
  localparam logic [11:0] A_ACK  = 12'h00C;
  localparam logic [11:0] A_RAW  = 12'h010;
  localparam logic [11:0] A_MSK  = 12'h014;
  localparam logic [11:0] A_KEY  = 12'hC00;
  localparam logic [31:0] KEY    = 32'h1ACC_E551;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        psel = 1'b0;
  logic        penable = 1'b0;
  logic        pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        irq_o;
  logic        wdog_rst_o;

  int checks = 0;
  int errors = 0;

  wdog2_top dut (
    .clk        (clk),
    .rst        (rst),
    .psel       (psel),
    .penable    (penable),
    .pwrite     (pwrite),
    .paddr      (paddr),
    .pwdata     (pwdata),
    .prdata     (prdata),
    .irq_o      (irq_o),
    .wdog_rst_o (wdog_rst_o)
  );

  always #5 clk = ~clk;

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
    @(posedge clk); @(negedge clk);
    penable = 1'b1;
    @(posedge clk); @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
    psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
    @(posedge clk); @(negedge clk);
    penable = 1'b1;
    d = prdata;
    @(posedge clk); @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic rd_chk(input string what, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    bus_rd(a, d);
    chk(what, d, exp);
  endtask

  task automatic block_reset();
    rst = 1'b1;
    step(2);
    rst = 1'b0;
    step(1);
  endtask

  task automatic t_reset_state();
    chk("R1 irq_o after reset", 32'(irq_o), 32'd0);
    chk("R1 wdog_rst_o after reset", 32'(wdog_rst_o), 32'd0);
    rd_chk("R1 R12 reload reset value", A_LOAD, 32'hFFFF_FFFF);
    rd_chk("R1 R12 counter reset value", A_CNT, 32'hFFFF_FFFF);
    rd_chk("R1 R12 control reset value", A_CTRL, 32'd0);
    rd_chk("R1 R9 key reads unlocked", A_KEY, 32'd0);
    rd_chk("R1 R8 raw flag clear", A_RAW, 32'd0);
  endtask

  task automatic t_reload_write();
    bus_wr(A_LOAD, 32'd100);
    rd_chk("R7 counter loaded by reload write", A_CNT, 32'd100);
    rd_chk("R7 reload readback", A_LOAD, 32'd100);
    rd_chk("R12 acknowledge reads zero", A_ACK, 32'd0);
  endtask

  task automatic t_count_live();
    bus_wr(A_LOAD, 32'd100);
    bus_wr(A_CTRL, 32'd1);
    step(10);
    bus_wr(A_CTRL, 32'd0);
    rd_chk("R2 live count after 12 clocks", A_CNT, 32'd88);
    step(5);
    rd_chk("R2 count holds while stopped", A_CNT, 32'd88);
  endtask

  task automatic t_first_expiry();
    bus_wr(A_LOAD, 32'd20);
    bus_wr(A_CTRL, 32'd1);
    step(20);
    chk("R3 no flag at L clocks", 32'(irq_o), 32'd0);
    step(1);
    chk("R3 irq_o at L+1 clocks", 32'(irq_o), 32'd1);
    bus_wr(A_CTRL, 32'd0);
    chk("R8 irq_o masked when stopped", 32'(irq_o), 32'd0);
    rd_chk("R8 raw shows flag when stopped", A_RAW, 32'd1);
    rd_chk("R8 masked zero when stopped", A_MSK, 32'd0);
    bus_wr(A_ACK, 32'hDEAD_BEEF);
    rd_chk("R6 acknowledge clears flag", A_RAW, 32'd0);
    rd_chk("R6 acknowledge reloads counter", A_CNT, 32'd20);
  endtask

  task automatic t_masked_running();
    bus_wr(A_LOAD, 32'd4);
    bus_wr(A_CTRL, 32'd1);
    step(6);
    rd_chk("R8 masked set while running", A_MSK, 32'd1);
    chk("R8 irq_o while running", 32'(irq_o), 32'd1);
    bus_wr(A_ACK, 32'd0);
    chk("R6 irq_o dropped by acknowledge", 32'(irq_o), 32'd0);
    bus_wr(A_CTRL, 32'd0);
  endtask

  task automatic t_no_reset_enable();
    bus_wr(A_LOAD, 32'd10);
    bus_wr(A_CTRL, 32'd1);
    step(30);
    chk("R5 no reset without enable", 32'(wdog_rst_o), 32'd0);
    chk("R5 flag stays set", 32'(irq_o), 32'd1);
    bus_wr(A_CTRL, 32'd0);
    bus_wr(A_ACK, 32'd0);
  endtask

  task automatic t_second_expiry();
    bus_wr(A_LOAD, 32'd15);
    bus_wr(A_CTRL, 32'd3);
    step(31);
    chk("R4 no reset one clock early", 32'(wdog_rst_o), 32'd0);
    step(1);
    chk("R4 reset at 2(L+1) clocks", 32'(wdog_rst_o), 32'd1);
    bus_wr(A_CTRL, 32'd0);
    step(5);
    chk("R4 reset is sticky", 32'(wdog_rst_o), 32'd1);
    block_reset();
    chk("R4 R1 block reset clears request", 32'(wdog_rst_o), 32'd0);
  endtask

  task automatic t_zero_load();
    bus_wr(A_LOAD, 32'd0);
    bus_wr(A_CTRL, 32'd3);
    chk("R11 no flag at enabling clock", 32'(irq_o), 32'd0);
    step(1);
    chk("R11 flag one clock after enable", 32'(irq_o), 32'd1);
    chk("R11 no reset yet", 32'(wdog_rst_o), 32'd0);
    step(1);
    chk("R11 reset two clocks after enable", 32'(wdog_rst_o), 32'd1);
    block_reset();
  endtask

  task automatic t_lock();
    bus_wr(A_KEY, 32'h0000_1234);
    rd_chk("R9 key reads locked", A_KEY, 32'd1);
    bus_wr(A_LOAD, 32'd77);
    rd_chk("R10 reload write ignored when locked", A_LOAD, 32'hFFFF_FFFF);
    rd_chk("R10 counter untouched when locked", A_CNT, 32'hFFFF_FFFF);
    bus_wr(A_CTRL, 32'd3);
    rd_chk("R10 control write ignored when locked", A_CTRL, 32'd0);
    bus_wr(A_KEY, KEY);
    rd_chk("R9 key reads unlocked", A_KEY, 32'd0);
    bus_wr(A_LOAD, 32'd77);
    rd_chk("R9 reload write accepted after unlock", A_LOAD, 32'd77);
    bus_wr(A_LOAD, 32'd3);
    bus_wr(A_CTRL, 32'd1);
    step(6);
    chk("R3 flag set before lock", 32'(irq_o), 32'd1);
    bus_wr(A_KEY, 32'd0);
    bus_wr(A_ACK, 32'd0);
    chk("R10 acknowledge ignored when locked", 32'(irq_o), 32'd1);
    bus_wr(A_CTRL, 32'd0);
    chk("R10 stop ignored when locked", 32'(irq_o), 32'd1);
    bus_wr(A_KEY, KEY);
    bus_wr(A_CTRL, 32'd0);
    bus_wr(A_ACK, 32'd0);
    rd_chk("R6 flag cleared after unlock", A_RAW, 32'd0);
  endtask

  task automatic t_keepalive();
    bus_wr(A_LOAD, 32'd20);
    bus_wr(A_CTRL, 32'd3);
    for (int k = 0; k < 6; k++) begin
      step(10);
      bus_wr(A_ACK, 32'(k));
      chk("R6 no flag while acknowledged", 32'(irq_o), 32'd0);
    end
    chk("R6 no reset while acknowledged", 32'(wdog_rst_o), 32'd0);
    bus_wr(A_CTRL, 32'd0);
  endtask

  initial begin
    rst = 1'b1;
    step(3);
    rst = 1'b0;
    step(1);
    t_reset_state();
    t_reload_write();
    t_count_live();
    t_first_expiry();
    t_masked_running();
    t_no_reset_enable();
    t_second_expiry();
    t_reset_state();
    t_zero_load();
    t_lock();
    t_keepalive();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule